// File: doc/BRIEF.md
# Operand Bypass and Pipeline Stall Controller

This block sits beside the decode and execute stages of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It reads the register numbers and a few control bits carried in the stage registers. From these it picks the source for each of the two ALU operands: the register-file read, the result held in the memory-stage register, or the result held in the writeback-stage register. When the nearest producer is a younger instruction it wins, and register 0 is never bypassed.

The block also decides when the front of the pipe must wait. A load in execute whose target feeds the instruction in decode forces a one-cycle hold. Branches compare their operands during decode, so they cannot take bypassed results from later stages in time. They wait one cycle behind an ALU producer in execute or a load in memory, and two cycles behind a load in execute. The second cycle of that longer wait comes from a small registered counter. While a stall is active, three strobes are raised together: hold the program counter, hold the fetch/decode register, and clear the control bits entering execute.

Top module: `fwd_stall_unit`

## Requirements
- R1: Operand select A (`fwdA`) is 2'b10 when `memRegWrite` is 1, `memDest` is nonzero and `memDest` equals `exRs`. Select B (`fwdB`) follows the same rule against `exRt`.
- R2: A select is 2'b01 when `wbRegWrite` is 1, `wbDest` is nonzero and equals that operand's register, and the R1 condition for that same operand is false. When both stages match, 2'b10 is chosen.
- R3: In every other case, including an operand register of 0 or a matching stage with its write bit clear, the select is 2'b00 (register-file value).
- R4: When `exMemRead` is 1 and `exRt` equals `decRs`, or equals `decRt` while `decUseRt` is 1, `holdPc`, `holdFetch` and `bubbleEx` are all 1 in that same cycle.
- R5: With `decUseRt` at 0, a match between `exRt` and `decRt` causes no stall.
- R6: With `decIsBranch` at 1, a stall is raised in the same cycle in either of two cases. The first is that execute holds a register-writing non-load (`exRegWrite`=1, `exMemRead`=0) whose nonzero `exDest` matches a branch source. The second is that the memory stage holds a load (`memMemRead`=1, `memRegWrite`=1) whose nonzero `memDest` matches a branch source. Branch sources are `decRs`, and `decRt` when `decUseRt` is 1.
- R7: With `decIsBranch` at 1, a load in execute (`exMemRead`=1, `exRegWrite`=1) with nonzero `exDest` matching a branch source causes a stall in that cycle. The stall also holds for the following cycle whatever the inputs are then.
- R8: A branch source matching only a non-load result in the memory stage, or only the writeback destination, causes no stall.
- R9: A non-branch decode instruction whose source matches a non-load producer in execute causes no stall.
- R10: A synchronous reset (`rst`=1 at a rising edge) clears a pending second branch-stall cycle, so the stall strobes are 0 afterward when no hazard is present on the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| decRs | input | 5 | First source register of the instruction in decode |
| decRt | input | 5 | Second source register of the instruction in decode |
| decUseRt | input | 1 | Decode instruction actually reads its second source |
| decIsBranch | input | 1 | Decode instruction is a branch compared in decode |
| exRs | input | 5 | First source register of the instruction in execute |
| exRt | input | 5 | Second source register of the instruction in execute |
| exDest | input | 5 | Register written by the instruction in execute |
| exRegWrite | input | 1 | Execute instruction writes a register |
| exMemRead | input | 1 | Execute instruction is a load |
| memDest | input | 5 | Register written by the instruction in the memory stage |
| memRegWrite | input | 1 | Memory-stage instruction writes a register |
| memMemRead | input | 1 | Memory-stage instruction is a load |
| wbDest | input | 5 | Register written by the instruction in writeback |
| wbRegWrite | input | 1 | Writeback instruction writes a register |
| fwdA | output | 2 | Source select for ALU operand A |
| fwdB | output | 2 | Source select for ALU operand B |
| holdPc | output | 1 | Keep the program counter unchanged |
| holdFetch | output | 1 | Keep the fetch/decode register unchanged |
| bubbleEx | output | 1 | Zero the control bits entering execute |

## Verification
The assertions assume the stage fields describe a pipe that moves forward coherently. In particular, a load presented in execute carries the same register in `exRt` and `exDest`. They also assume the second branch-stall cycle is judged only from the cycle after a trigger that was not already under reset. The stimulus keeps to this. Every table entry sets load fields consistently and places no branch behind a load in execute, so no entry leaves a counted stall behind for the next one. The two-cycle branch case and its cancellation by reset are driven separately, each from an idle pipe.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  // Operand source selects; the encodings are seen by the ALU input muxes
  typedef enum logic [1:0] {
    FWD_REGFILE = 2'b00,
    FWD_WB      = 2'b01,
    FWD_MEM     = 2'b10
  } fwdSel_t;

  // Hazard strobes reported by the comparator to the stall sequencer
  typedef struct packed {
    logic loadUse;
    logic branchNear;
    logic branchLoadNear;
  } hazardFlags_t;

  // Stall strobes driven toward the pipeline registers
  typedef struct packed {
    logic holdPc;
    logic holdFetch;
    logic bubbleEx;
  } stallCtl_t;

endpackage

// File: rtl/hzd_compare.sv
module hzd_compare
  import hzd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] decRs,
  input  logic [REG_W-1:0] decRt,
  input  logic             decUseRt,
  input  logic             decIsBranch,
  input  logic [REG_W-1:0] exRs,
  input  logic [REG_W-1:0] exRt,
  input  logic [REG_W-1:0] exDest,
  input  logic             exRegWrite,
  input  logic             exMemRead,
  input  logic [REG_W-1:0] memDest,
  input  logic             memRegWrite,
  input  logic             memMemRead,
  input  logic [REG_W-1:0] wbDest,
  input  logic             wbRegWrite,
  output fwdSel_t          fwdA,
  output fwdSel_t          fwdB,
  output hazardFlags_t     flags
);

  localparam int NUM_OPS = 2;

  logic [REG_W-1:0] srcReg [NUM_OPS];
  fwdSel_t          opSel  [NUM_OPS];

  assign srcReg[0] = exRs;
  assign srcReg[1] = exRt;

  // One bypass selector per ALU operand; the memory stage is nearer and wins
  for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
    logic memHit;
    logic wbHit;
    assign memHit   = memRegWrite && (memDest != '0) && (memDest == srcReg[i]);
    assign wbHit    = wbRegWrite  && (wbDest  != '0) && (wbDest  == srcReg[i]);
    assign opSel[i] = memHit ? FWD_MEM : (wbHit ? FWD_WB : FWD_REGFILE);
  end

  assign fwdA = opSel[0];
  assign fwdB = opSel[1];

  // Does a register feed the decode instruction's sources?
  function automatic logic feedsDecode(input logic [REG_W-1:0] r);
    return (r == decRs) || (decUseRt && (r == decRt));
  endfunction

  logic exAluHit;
  logic exLoadHit;
  logic memLoadHit;

  assign exAluHit   = exRegWrite && !exMemRead && (exDest != '0) && feedsDecode(exDest);
  assign exLoadHit  = exRegWrite && exMemRead && (exDest != '0) && feedsDecode(exDest);
  assign memLoadHit = memRegWrite && memMemRead && (memDest != '0) && feedsDecode(memDest);

  always_comb begin
    flags.loadUse        = exMemRead && feedsDecode(exRt);
    flags.branchNear     = decIsBranch && (exAluHit || memLoadHit);
    flags.branchLoadNear = decIsBranch && exLoadHit;
  end

  // R1
  mem_sel_source_chk: assert property (@(posedge clk) disable iff (rst)
    (fwdA == FWD_MEM) |-> (memRegWrite && (memDest != '0) && (memDest == exRs)));

  // R2
  wb_sel_priority_chk: assert property (@(posedge clk) disable iff (rst)
    (fwdB == FWD_WB) |-> !(memRegWrite && (memDest != '0) && (memDest == exRt)));

  // R3
  sel_code_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (fwdA != 2'b11) && (fwdB != 2'b11));

endmodule

// File: rtl/hzd_stall_seq.sv
module hzd_stall_seq
  import hzd_pkg::*;
#(
  parameter int MAX_BR_STALL = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  hazardFlags_t flags,
  output stallCtl_t    stall
);

  localparam int CNT_W = (MAX_BR_STALL > 2) ? $clog2(MAX_BR_STALL) : 1;
  localparam logic [CNT_W-1:0] EXTRA_CYCLES = CNT_W'(MAX_BR_STALL - 1);

  logic [CNT_W-1:0] extraCnt;
  logic             stallNow;

  assign stallNow = flags.loadUse || flags.branchNear || flags.branchLoadNear
                    || (extraCnt != '0);

  // Counts the stall cycles still owed after a branch sees a load in execute
  always_ff @(posedge clk) begin
    if (rst)
      extraCnt <= '0;
    else if (extraCnt != '0)
      extraCnt <= extraCnt - 1'b1;
    else if (flags.branchLoadNear)
      extraCnt <= EXTRA_CYCLES;
  end

  always_comb begin
    stall.holdPc    = stallNow;
    stall.holdFetch = stallNow;
    stall.bubbleEx  = stallNow;
  end

  // R7
  branch_load_extend_chk: assert property (@(posedge clk) disable iff (rst)
    (flags.branchLoadNear && (extraCnt == '0)) |=> stall.holdPc);

  // R7
  extra_cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    extraCnt <= EXTRA_CYCLES);

  // R4
  load_use_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    flags.loadUse |-> (stall.bubbleEx && stall.holdFetch && stall.holdPc));

  // R10
  reset_clears_chk: assert property (@(posedge clk)
    $past(rst) |-> (extraCnt == '0));

endmodule

// File: rtl/fwd_stall_unit.sv
module fwd_stall_unit
  import hzd_pkg::*;
#(
  parameter int REG_W        = 5,
  parameter int MAX_BR_STALL = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] decRs,
  input  logic [REG_W-1:0] decRt,
  input  logic             decUseRt,
  input  logic             decIsBranch,
  input  logic [REG_W-1:0] exRs,
  input  logic [REG_W-1:0] exRt,
  input  logic [REG_W-1:0] exDest,
  input  logic             exRegWrite,
  input  logic             exMemRead,
  input  logic [REG_W-1:0] memDest,
  input  logic             memRegWrite,
  input  logic             memMemRead,
  input  logic [REG_W-1:0] wbDest,
  input  logic             wbRegWrite,
  output logic [1:0]       fwdA,
  output logic [1:0]       fwdB,
  output logic             holdPc,
  output logic             holdFetch,
  output logic             bubbleEx
);

  fwdSel_t      selA;
  fwdSel_t      selB;
  hazardFlags_t hzFlags;
  stallCtl_t    stallOut;

  hzd_compare #(.REG_W(REG_W)) u_compare (
    .clk(clk), .rst(rst),
    .decRs(decRs), .decRt(decRt), .decUseRt(decUseRt), .decIsBranch(decIsBranch),
    .exRs(exRs), .exRt(exRt), .exDest(exDest),
    .exRegWrite(exRegWrite), .exMemRead(exMemRead),
    .memDest(memDest), .memRegWrite(memRegWrite), .memMemRead(memMemRead),
    .wbDest(wbDest), .wbRegWrite(wbRegWrite),
    .fwdA(selA), .fwdB(selB), .flags(hzFlags)
  );

  hzd_stall_seq #(.MAX_BR_STALL(MAX_BR_STALL)) u_seq (
    .clk(clk), .rst(rst), .flags(hzFlags), .stall(stallOut)
  );

  assign fwdA      = selA;
  assign fwdB      = selB;
  assign holdPc    = stallOut.holdPc;
  assign holdFetch = stallOut.holdFetch;
  assign bubbleEx  = stallOut.bubbleEx;

endmodule

// File: tb/fwd_stall_unit_test.sv
module fwd_stall_unit_test;

  logic clk = 1'b0;
  logic rst;
  logic [4:0] decRs, decRt, exRs, exRt, exDest, memDest, wbDest;
  logic decUseRt, decIsBranch, exRegWrite, exMemRead, memRegWrite, memMemRead, wbRegWrite;
  logic [1:0] fwdA, fwdB;
  logic holdPc, holdFetch, bubbleEx;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  fwd_stall_unit uut (
    .clk(clk), .rst(rst),
    .decRs(decRs), .decRt(decRt), .decUseRt(decUseRt), .decIsBranch(decIsBranch),
    .exRs(exRs), .exRt(exRt), .exDest(exDest),
    .exRegWrite(exRegWrite), .exMemRead(exMemRead),
    .memDest(memDest), .memRegWrite(memRegWrite), .memMemRead(memMemRead),
    .wbDest(wbDest), .wbRegWrite(wbRegWrite),
    .fwdA(fwdA), .fwdB(fwdB),
    .holdPc(holdPc), .holdFetch(holdFetch), .bubbleEx(bubbleEx)
  );

  typedef struct packed {
    logic [3:0] req;
    logic [4:0] dRs; logic [4:0] dRt; logic dUse; logic dBr;
    logic [4:0] eRs; logic [4:0] eRt; logic [4:0] eDst; logic eWr; logic eRd;
    logic [4:0] mDst; logic mWr; logic mRd;
    logic [4:0] wDst; logic wWr;
    logic [1:0] xA; logic [1:0] xB; logic xS;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{1, 0,0,0,0, 3,4,0,0,0, 3,1,0, 0,0, 2,0,0},  // R1 operand A from memory stage
    '{1, 0,0,0,0, 5,6,0,0,0, 6,1,0, 0,0, 0,2,0},  // R1 operand B from memory stage
    '{2, 0,0,0,0, 7,8,0,0,0, 0,0,0, 7,1, 1,0,0},  // R2 operand A from writeback
    '{2, 0,0,0,0, 2,2,0,0,0, 2,1,0, 2,1, 2,2,0},  // R2 both stages match, nearest wins
    '{2, 0,0,0,0, 2,9,0,0,0, 2,1,0, 9,1, 2,1,0},  // R2 mixed sources
    '{3, 0,0,0,0, 0,0,0,0,0, 0,1,0, 0,1, 0,0,0},  // R3 register 0 never bypassed
    '{3, 0,0,0,0, 3,3,0,0,0, 3,0,0, 3,0, 0,0,0},  // R3 no write enable
    '{4, 4,0,0,0, 0,4,4,1,1, 0,0,0, 0,0, 0,0,1},  // R4 load feeds first source
    '{4, 1,4,1,0, 0,4,4,1,1, 0,0,0, 0,0, 0,0,1},  // R4 load feeds second source
    '{5, 1,4,0,0, 0,4,4,1,1, 0,0,0, 0,0, 0,0,0},  // R5 second source unused
    '{9, 6,0,0,0, 0,0,6,1,0, 0,0,0, 0,0, 0,0,0},  // R9 ALU producer, non-branch
    '{6, 6,1,1,1, 0,0,6,1,0, 0,0,0, 0,0, 0,0,1},  // R6 branch behind ALU producer
    '{6, 2,3,1,1, 0,0,0,0,0, 3,1,1, 0,0, 0,0,1},  // R6 branch behind load two back
    '{8, 5,1,1,1, 0,0,0,0,0, 5,1,0, 0,0, 0,0,0},  // R8 ALU two back is bypassed
    '{8, 1,5,1,1, 0,0,0,0,0, 0,0,0, 5,1, 0,0,0},  // R8 third back is bypassed
    '{6, 0,1,1,1, 0,0,0,1,0, 0,0,0, 0,0, 0,0,0}   // R6 register 0 match is no hazard
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idleInputs();
    decRs = 0; decRt = 0; decUseRt = 0; decIsBranch = 0;
    exRs = 0; exRt = 0; exDest = 0; exRegWrite = 0; exMemRead = 0;
    memDest = 0; memRegWrite = 0; memMemRead = 0;
    wbDest = 0; wbRegWrite = 0;
  endtask

  task automatic checkStall(input string req, input logic exp);
    logic [2:0] act;
    act = {holdPc, holdFetch, bubbleEx};
    check(act == {3{exp}}, req, "stall strobes", 32'(act), 32'({3{exp}}));
  endtask

  // Branch whose first source is loaded by the instruction in execute
  task automatic branchBehindLoad();
    idleInputs();
    decRs = 7; decRt = 1; decUseRt = 1; decIsBranch = 1;
    exRt = 7; exDest = 7; exRegWrite = 1; exMemRead = 1;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1;
    idleInputs();
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    #2;
    // Reset state with an idle pipe
    check(fwdA == 2'b00, "R3", "reset fwdA", 32'(fwdA), 0);
    check(fwdB == 2'b00, "R3", "reset fwdB", 32'(fwdB), 0);
    checkStall("R10", 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      decRs = VECS[i].dRs; decRt = VECS[i].dRt;
      decUseRt = VECS[i].dUse; decIsBranch = VECS[i].dBr;
      exRs = VECS[i].eRs; exRt = VECS[i].eRt; exDest = VECS[i].eDst;
      exRegWrite = VECS[i].eWr; exMemRead = VECS[i].eRd;
      memDest = VECS[i].mDst; memRegWrite = VECS[i].mWr; memMemRead = VECS[i].mRd;
      wbDest = VECS[i].wDst; wbRegWrite = VECS[i].wWr;
      #2;
      check(fwdA == VECS[i].xA, $sformatf("R%0d", VECS[i].req), $sformatf("vec %0d fwdA", i),
            32'(fwdA), 32'(VECS[i].xA));
      check(fwdB == VECS[i].xB, $sformatf("R%0d", VECS[i].req), $sformatf("vec %0d fwdB", i),
            32'(fwdB), 32'(VECS[i].xB));
      checkStall($sformatf("R%0d", VECS[i].req), VECS[i].xS);
    end

    // R7: two-cycle stall, second cycle held with idle inputs
    @(negedge clk) branchBehindLoad();
    #2 checkStall("R7", 1'b1);
    @(negedge clk) idleInputs();
    #2 checkStall("R7", 1'b1);
    @(negedge clk);
    #2 checkStall("R7", 1'b0);

    // R10: reset cancels the owed second cycle
    @(negedge clk) branchBehindLoad();
    #2 checkStall("R10", 1'b1);
    @(negedge clk) begin idleInputs(); rst = 1; end
    @(negedge clk) rst = 0;
    #2 checkStall("R10", 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule